// File: doc/BRIEF.md
# RAID-6 Double-Erasure Symbol Solver

This block rebuilds the contents of the disks that have been lost from a stripe protected by two checksum disks, P and Q. For each 32-bit word position, upstream logic has already removed the surviving data from the stored checksums. What it delivers is a pair of partial syndromes. P' is the XOR of the stored P with every surviving data word. Q' is the XOR of the stored Q with every surviving data word weighted by g^i. The block also receives the indices of the one or two failed disks. It returns the regenerated words for the failed data disks, or a flag saying that only checksums were lost and must be re-encoded, or an error flag for a malformed request.

The arithmetic works on 4-bit symbols in GF(16) with the field polynomial x^4+x+1 and generator g = 2. A 32-bit word is split into eight independent nibble lanes: lane k is bits 4k+3..4k. Addition and subtraction are XOR. Division subtracts logarithms modulo 15 and then takes the antilogarithm. Disk indices 0 to N_DATA-1 are data disks, index N_DATA is P and index N_DATA+1 is Q. The default N_DATA is 12, which gives a 14-disk array, and N_DATA may be as large as 14. Any index of N_DATA+2 or above is out of range.

Requests and results each travel on a valid/ready stream. The pipeline moves forward only while its output slot is empty or being taken (`out_ready` high). When `out_valid` is high and `out_ready` is low, every stage holds, the result stays on the outputs unchanged, and `in_ready` is low. An input is accepted on a rising edge where `in_valid` and `in_ready` are both high.

Top module: `raid6_erasure_solver`

## Requirements
- R1: With `in_dual` low, only `in_fail_a` is used. If it names a data disk, `out_have_a` is 1 and `out_data_a` = P'. `out_have_b` is 0 and `out_data_b` is 0. The value of `in_fail_b` has no effect.
- R2: If one data disk x and Q are lost (in either index slot), the word for x equals P'. It is presented on the data output of the slot that named x, and that slot's have flag is set.
- R3: If one data disk x and P are lost (in either slot), the word for x equals Q' / g^x in every lane. A lane where Q' is zero gives zero.
- R4: If two distinct data disks x and y are lost, Dx = (g^y·P' + Q') / (g^x + g^y) and Dy = P' + Dx in every lane. Both have flags are set, and each word appears on the output of the slot that named it, whatever the order.
- R5: If no data disk is lost, `out_reencode` is 1, both have flags are 0 and both data outputs are 0. This covers P alone, Q alone, and P with Q.
- R6: If either used index is N_DATA+2 or above, or if `in_dual` is high and both indices are equal, `out_error` is 1. `out_reencode` and both have flags are 0, and both data outputs are 0.
- R7: A result appears exactly three rising edges after acceptance when nothing stalls. The acceptance edge counts as the first of the three. No result ever appears without an accepted request.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, the outputs hold stable and any offered input is ignored. The output is released on the first edge with `out_ready` high.
- R9: Reset (active-low `rst_n`) empties the pipeline. `out_valid` is 0 and `in_ready` is 1, and a request that was in flight when reset arrived never emerges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this edge |
| in_dual | input | 1 | 1: two disks failed, 0: only `in_fail_a` failed |
| in_fail_a | input | 4 | First failed disk index |
| in_fail_b | input | 4 | Second failed disk index (used when `in_dual` is 1) |
| in_psyn | input | 32 | Partial P syndrome P' |
| in_qsyn | input | 32 | Partial Q syndrome Q' |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data_a | output | 32 | Regenerated word for the disk named by `in_fail_a` |
| out_data_b | output | 32 | Regenerated word for the disk named by `in_fail_b` |
| out_have_a | output | 1 | `out_data_a` holds a regenerated data word |
| out_have_b | output | 1 | `out_data_b` holds a regenerated data word |
| out_reencode | output | 1 | Only checksum disks were lost |
| out_error | output | 1 | Request rejected |

## Verification
Every solving result is due three rising edges after the edge that accepts the request. The bench drives a request half a cycle before its accepting edge, lets two more edges pass, and samples all outputs at the falling edge that follows. It then checks one cycle later that `out_valid` has gone low again. Under back-pressure the result is sampled on the stall cycles and again after release, which shows it was held and that no rejected input slipped through. For reset, an in-flight request is cleared and the bench checks over the cycles where its result would have been due that nothing appears. The expected words come from encoding known lost data into syndromes with an independent shift-and-add GF(16) multiply.

// File: rtl/raid6_gf_pkg.sv
package raid6_gf_pkg;

  localparam int SYM_W       = 4;
  localparam int FIELD_ORDER = 15;
  localparam logic [SYM_W-1:0] POLY_LOW = 4'h3;

  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [2:0] {
    SV_ERROR,
    SV_REENC,
    SV_COPY,
    SV_DIVQ,
    SV_PAIR
  } solve_t;

  function automatic sym_t gf_xtime(sym_t a);
    sym_t r;
    r = {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? POLY_LOW : '0);
    return r;
  endfunction

  function automatic sym_t gf_exp(sym_t e);
    sym_t v;
    v = sym_t'(1);
    for (int i = 0; i < FIELD_ORDER; i++) begin
      if (i < int'(e)) v = gf_xtime(v);
    end
    return v;
  endfunction

  function automatic sym_t gf_log(sym_t v);
    sym_t r;
    r = '0;
    for (int k = 0; k < FIELD_ORDER; k++) begin
      if (gf_exp(sym_t'(k)) == v) r = sym_t'(k);
    end
    return r;
  endfunction

  function automatic sym_t gf_addlog(sym_t a, sym_t b);
    logic [SYM_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (SYM_W+1)'(FIELD_ORDER)) s = s - (SYM_W+1)'(FIELD_ORDER);
    return s[SYM_W-1:0];
  endfunction

  function automatic sym_t gf_sublog(sym_t a, sym_t b);
    logic [SYM_W:0] s;
    s = {1'b0, a} + (SYM_W+1)'(FIELD_ORDER) - {1'b0, b};
    if (s >= (SYM_W+1)'(FIELD_ORDER)) s = s - (SYM_W+1)'(FIELD_ORDER);
    return s[SYM_W-1:0];
  endfunction

  function automatic sym_t gf_mulpow(sym_t a, sym_t k);
    sym_t r;
    if (a == '0) r = '0;
    else         r = gf_exp(gf_addlog(gf_log(a), k));
    return r;
  endfunction

endpackage

// File: rtl/raid6_case_decode.sv
module raid6_case_decode
  import raid6_gf_pkg::*;
#(
  parameter int N_DATA = 12
) (
  input  logic   dual,
  input  sym_t   fail_a,
  input  sym_t   fail_b,
  output solve_t kind,
  output sym_t   idx_x,
  output sym_t   idx_y,
  output logic   swap
);

  localparam int N_DISK = N_DATA + 2;

  logic a_ok, b_ok, a_data, b_data, a_q, b_q;

  assign a_ok   = int'(fail_a) < N_DISK;
  assign b_ok   = int'(fail_b) < N_DISK;
  assign a_data = int'(fail_a) < N_DATA;
  assign b_data = int'(fail_b) < N_DATA;
  assign a_q    = int'(fail_a) == N_DATA + 1;
  assign b_q    = int'(fail_b) == N_DATA + 1;

  always_comb begin
    kind  = SV_ERROR;
    idx_x = fail_a;
    idx_y = fail_b;
    swap  = 1'b0;
    if (!dual) begin
      if (!a_ok)       kind = SV_ERROR;
      else if (a_data) kind = SV_COPY;
      else             kind = SV_REENC;
    end else if (!a_ok || !b_ok || (fail_a == fail_b)) begin
      kind = SV_ERROR;
    end else if (a_data && b_data) begin
      kind = SV_PAIR;
    end else if (a_data) begin
      kind = b_q ? SV_COPY : SV_DIVQ;
    end else if (b_data) begin
      swap  = 1'b1;
      idx_x = fail_b;
      idx_y = fail_a;
      kind  = a_q ? SV_COPY : SV_DIVQ;
    end else begin
      kind = SV_REENC;
    end
  end

endmodule

// File: rtl/raid6_lane.sv
module raid6_lane
  import raid6_gf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv,
  input  solve_t kind_d,
  input  solve_t kind_2,
  input  logic   swap_2,
  input  sym_t   idx_x,
  input  sym_t   idx_y,
  input  sym_t   p_in,
  input  sym_t   q_in,
  output sym_t   out_a,
  output sym_t   out_b
);

  sym_t num_d, den_d;
  sym_t num_1, den_1, p_1;
  sym_t lq_2, p_2;
  logic nz_2;
  sym_t dx, wx, wy;

  // stage 1: numerator and log of the divisor
  always_comb begin
    if (kind_d == SV_PAIR) begin
      num_d = gf_mulpow(p_in, idx_y) ^ q_in;
      den_d = gf_log(gf_exp(idx_x) ^ gf_exp(idx_y));
    end else begin
      num_d = q_in;
      den_d = idx_x;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_1 <= '0;
      den_1 <= '0;
      p_1   <= '0;
    end else if (adv) begin
      num_1 <= num_d;
      den_1 <= den_d;
      p_1   <= p_in;
    end
  end

  // stage 2: quotient in the log domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nz_2 <= 1'b0;
      lq_2 <= '0;
      p_2  <= '0;
    end else if (adv) begin
      nz_2 <= (num_1 != '0);
      lq_2 <= gf_sublog(gf_log(num_1), den_1);
      p_2  <= p_1;
    end
  end

  // stage 3: antilog and word selection
  always_comb begin
    dx = nz_2 ? gf_exp(lq_2) : '0;
    wx = '0;
    wy = '0;
    unique case (kind_2)
      SV_PAIR: begin wx = dx;  wy = p_2 ^ dx; end
      SV_DIVQ: wx = dx;
      SV_COPY: wx = p_2;
      default: begin wx = '0; wy = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_a <= '0;
      out_b <= '0;
    end else if (adv) begin
      out_a <= swap_2 ? wy : wx;
      out_b <= swap_2 ? wx : wy;
    end
  end

endmodule

// File: rtl/raid6_erasure_solver.sv
module raid6_erasure_solver
  import raid6_gf_pkg::*;
#(
  parameter int N_DATA = 12,
  parameter int LANES  = 8,
  localparam int WORD_W = LANES * SYM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_dual,
  input  logic [SYM_W-1:0]  in_fail_a,
  input  logic [SYM_W-1:0]  in_fail_b,
  input  logic [WORD_W-1:0] in_psyn,
  input  logic [WORD_W-1:0] in_qsyn,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data_a,
  output logic [WORD_W-1:0] out_data_b,
  output logic              out_have_a,
  output logic              out_have_b,
  output logic              out_reencode,
  output logic              out_error
);

  solve_t kind_d, kind_1, kind_2;
  sym_t   idx_x, idx_y;
  logic   swap_d, swap_1, swap_2;
  logic   valid_1, valid_2;
  logic   adv, accept;
  logic   solo;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign accept   = in_valid && adv;

  raid6_case_decode #(.N_DATA(N_DATA)) u_decode (
    .dual   (in_dual),
    .fail_a (in_fail_a),
    .fail_b (in_fail_b),
    .kind   (kind_d),
    .idx_x  (idx_x),
    .idx_y  (idx_y),
    .swap   (swap_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_1 <= 1'b0;
      valid_2 <= 1'b0;
      kind_1  <= SV_ERROR;
      kind_2  <= SV_ERROR;
      swap_1  <= 1'b0;
      swap_2  <= 1'b0;
    end else if (adv) begin
      valid_1 <= accept;
      kind_1  <= accept ? kind_d : SV_ERROR;
      swap_1  <= accept && swap_d;
      valid_2 <= valid_1;
      kind_2  <= kind_1;
      swap_2  <= swap_1;
    end
  end

  assign solo = (kind_2 == SV_COPY) || (kind_2 == SV_DIVQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_have_a   <= 1'b0;
      out_have_b   <= 1'b0;
      out_reencode <= 1'b0;
      out_error    <= 1'b0;
    end else if (adv) begin
      out_valid    <= valid_2;
      out_have_a   <= valid_2 && ((kind_2 == SV_PAIR) || (solo && !swap_2));
      out_have_b   <= valid_2 && ((kind_2 == SV_PAIR) || (solo && swap_2));
      out_reencode <= valid_2 && (kind_2 == SV_REENC);
      out_error    <= valid_2 && (kind_2 == SV_ERROR);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    raid6_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .kind_d (kind_d),
      .kind_2 (kind_2),
      .swap_2 (swap_2),
      .idx_x  (idx_x),
      .idx_y  (idx_y),
      .p_in   (in_psyn[k*SYM_W +: SYM_W]),
      .q_in   (in_qsyn[k*SYM_W +: SYM_W]),
      .out_a  (out_data_a[k*SYM_W +: SYM_W]),
      .out_b  (out_data_b[k*SYM_W +: SYM_W])
    );
  end

endmodule

// File: rtl/raid6_erasure_solver_chk.sv
module raid6_erasure_solver_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data_a,
  input logic [WORD_W-1:0] out_data_b,
  input logic              out_have_a,
  input logic              out_have_b,
  input logic              out_reencode,
  input logic              out_error
);

  logic [2:0] occ;
  logic       acc, drain;

  assign acc   = in_valid && in_ready;
  assign drain = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + {2'b0, acc} - {2'b0, drain};
  end

  // R8: a stalled result holds still
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data_a) && $stable(out_data_b)
      && $stable(out_have_a) && $stable(out_have_b) && $stable(out_reencode) && $stable(out_error)));

  // R8: the input is refused only while a result waits
  a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R6: a rejected request carries no data
  a_r6_error_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_error) |-> (!out_have_a && !out_have_b && !out_reencode
      && out_data_a == '0 && out_data_b == '0));

  // R5: a re-encode result carries no data
  a_r5_reenc_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_reencode) |-> (!out_have_a && !out_have_b && out_data_a == '0 && out_data_b == '0));

  // R7: never more than three requests in flight
  a_r7_depth: assert property (@(posedge clk) disable iff (!rst_n) occ <= 3'd3);

  // R7: no result without an accepted request
  a_r7_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 3'd0) |-> !out_valid);

endmodule

bind raid6_erasure_solver raid6_erasure_solver_chk #(.WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_raid6_erasure_solver.sv
module test_raid6_erasure_solver;

  localparam int CLK_PERIOD = 10;
  localparam int NDATA = 12;
  localparam logic [31:0] JUNK_P = 32'h5A3C_96E1;
  localparam logic [31:0] JUNK_Q = 32'hC71D_2B84;

  typedef struct packed {
    logic        dual;
    logic [3:0]  fa;
    logic [3:0]  fb;
    logic [31:0] da;
    logic [31:0] db;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 4'd3,  4'd9,  32'h1234_ABCD, 32'h0000_0000},
    '{1'b0, 4'd0,  4'd0,  32'hFEDC_0123, 32'h0000_0000},
    '{1'b1, 4'd2,  4'd7,  32'h89AB_CDEF, 32'h1357_9BDF},
    '{1'b1, 4'd7,  4'd2,  32'h1357_9BDF, 32'h89AB_CDEF},
    '{1'b1, 4'd0,  4'd11, 32'hA5A5_5A5A, 32'h0F1E_2D3C},
    '{1'b1, 4'd5,  4'd13, 32'h7766_5544, 32'h0000_0000},
    '{1'b1, 4'd12, 4'd4,  32'h0000_0000, 32'hBEEF_F00D},
    '{1'b1, 4'd9,  4'd12, 32'hCAFE_1234, 32'h0000_0000},
    '{1'b1, 4'd13, 4'd1,  32'h0000_0000, 32'h4321_8765},
    '{1'b1, 4'd12, 4'd13, 32'h1111_2222, 32'h3333_4444},
    '{1'b0, 4'd12, 4'd3,  32'h9999_8888, 32'h7777_6666},
    '{1'b1, 4'd6,  4'd6,  32'h2468_ACE0, 32'h1357_9BDF},
    '{1'b1, 4'd3,  4'd14, 32'h0102_0304, 32'h0506_0708},
    '{1'b0, 4'd15, 4'd2,  32'hFFFF_FFFF, 32'h0000_0000},
    '{1'b1, 4'd11, 4'd10, 32'h0000_F00F, 32'hFFFF_0000},
    '{1'b1, 4'd1,  4'd12, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_dual, out_ready;
  logic [3:0]  in_fail_a, in_fail_b;
  logic [31:0] in_psyn, in_qsyn;
  logic        in_ready, out_valid;
  logic [31:0] out_data_a, out_data_b;
  logic        out_have_a, out_have_b, out_reencode, out_error;

  int checks = 0;
  int errors = 0;

  logic [31:0] ea, eb;
  logic [3:0]  eflags;

  always #(CLK_PERIOD/2) clk = ~clk;

  raid6_erasure_solver i_raid6_erasure_solver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dual(in_dual), .in_fail_a(in_fail_a), .in_fail_b(in_fail_b),
    .in_psyn(in_psyn), .in_qsyn(in_qsyn), .out_valid(out_valid), .out_ready(out_ready),
    .out_data_a(out_data_a), .out_data_b(out_data_b), .out_have_a(out_have_a),
    .out_have_b(out_have_b), .out_reencode(out_reencode), .out_error(out_error)
  );

  function automatic logic [3:0] bmul(logic [3:0] a, logic [3:0] b);
    logic [3:0] r, s;
    r = '0;
    s = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) r = r ^ s;
      s = {s[2:0], 1'b0} ^ (s[3] ? 4'h3 : 4'h0);
    end
    return r;
  endfunction

  function automatic logic [3:0] gpow(int k);
    logic [3:0] r;
    r = 4'h1;
    for (int i = 0; i < k; i++) r = bmul(r, 4'h2);
    return r;
  endfunction

  function automatic logic [31:0] wmul(logic [31:0] w, int k);
    logic [31:0] r;
    r = '0;
    for (int l = 0; l < 8; l++) r[l*4 +: 4] = bmul(w[l*4 +: 4], gpow(k));
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Builds syndromes from the lost data and sets the expected result
  task automatic prepare(vec_t v);
    logic err, ha, hb, lp, lq;
    logic [31:0] p, q;
    err = (int'(v.fa) >= NDATA + 2) ||
          (v.dual && ((int'(v.fb) >= NDATA + 2) || v.fa == v.fb));
    p = '0; q = '0; ea = '0; eb = '0; ha = 1'b0; hb = 1'b0;
    lp = (int'(v.fa) == NDATA) || (v.dual && int'(v.fb) == NDATA);
    lq = (int'(v.fa) == NDATA + 1) || (v.dual && int'(v.fb) == NDATA + 1);
    if (err) begin
      p = v.da; q = v.db;
    end else begin
      if (int'(v.fa) < NDATA) begin
        p = p ^ v.da; q = q ^ wmul(v.da, int'(v.fa)); ha = 1'b1; ea = v.da;
      end
      if (v.dual && int'(v.fb) < NDATA) begin
        p = p ^ v.db; q = q ^ wmul(v.db, int'(v.fb)); hb = 1'b1; eb = v.db;
      end
      if (lp) p = JUNK_P;
      if (lq) q = JUNK_Q;
    end
    eflags = {ha, hb, !err && !ha && !hb, err};
    in_dual = v.dual; in_fail_a = v.fa; in_fail_b = v.fb;
    in_psyn = p; in_qsyn = q;
  endtask

  function automatic string vtag(vec_t v);
    if (int'(v.fa) >= NDATA + 2 || (v.dual && (int'(v.fb) >= NDATA + 2 || v.fa == v.fb))) return "R6";
    if (!v.dual) return (int'(v.fa) < NDATA) ? "R1" : "R5";
    if (int'(v.fa) < NDATA && int'(v.fb) < NDATA) return "R4";
    if (int'(v.fa) < NDATA || int'(v.fb) < NDATA)
      return (int'(v.fa) == NDATA + 1 || int'(v.fb) == NDATA + 1) ? "R2" : "R3";
    return "R5";
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    checks++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_dual = 1'b0; out_ready = 1'b1;
    in_fail_a = '0; in_fail_b = '0; in_psyn = '0; in_qsyn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset out_valid", {63'b0, out_valid}, 64'd0);
    check("R9 reset in_ready", {63'b0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: accept edge, two more edges, sample on the falling edge
    for (int i = 0; i < NVEC; i++) begin
      prepare(TBL[i]);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check({vtag(TBL[i]), " R7 valid"}, {63'b0, out_valid}, 64'd1);
      check({vtag(TBL[i]), " data_a"}, {32'b0, out_data_a}, {32'b0, ea});
      check({vtag(TBL[i]), " data_b"}, {32'b0, out_data_b}, {32'b0, eb});
      check({vtag(TBL[i]), " flags"}, {60'b0, out_have_a, out_have_b, out_reencode, out_error},
            {60'b0, eflags});
      @(negedge clk);
      check("R7 single result", {63'b0, out_valid}, 64'd0);
    end

    // back-pressure
    out_ready = 1'b0;
    prepare(TBL[2]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R8 stalled valid", {63'b0, out_valid}, 64'd1);
    check("R8 in_ready low", {63'b0, in_ready}, 64'd0);
    prepare(TBL[0]);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check("R8 held data_a", {32'b0, out_data_a}, {32'b0, TBL[2].da});
    check("R8 held data_b", {32'b0, out_data_b}, {32'b0, TBL[2].db});
    check("R8 held valid", {63'b0, out_valid}, 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 released", {63'b0, out_valid}, 64'd0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R8 refused input absent", {63'b0, out_valid}, 64'd0);
    end

    // reset with a request in flight
    prepare(TBL[4]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R9 flushed", {63'b0, out_valid}, 64'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule